// File: doc/BRIEF.md
# ECC Error Log Capture Register

This block records errors reported by a memory-side ECC checker into a single 64-bit log word that software reads over a simple register bus. A checker pulses an error strobe with a correctable (CE) or uncorrectable (UE) flag, the failing address at 32-byte granularity and a 16-bit syndrome. The log word holds the type, address and syndrome. A 16-bit status register records the type of the error that was signalled, and a 16-bit command register enables the interrupt per type.

After an error is signalled, the log flags and the status bits both stay set until software writes 1s to them. No further error is signalled until both are clear. While a flag is set, the logged address and syndrome are frozen. The one exception is an uncorrectable error arriving over a logged correctable one, which replaces the entry. The interrupt request is a level that stays high while an enabled status bit is pending.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, the log, status and command registers read 0 and `irq_o` is low. Selecting `reg_sel_i` = 3 reads 0. The register select encoding is 0 = log word, 1 = status, 2 = command.
- R2: An error strobe with CE only, arriving when the log flags and the status bits are all clear, does the following. It sets log bit 62. It stores address bits 5..38 at log bits 5..38 and the syndrome at log bits 46..61. It sets status bit 6.
- R3: When a strobe carries UE, whether or not CE is also set, the log records it as uncorrectable. Log bit 63 and status bit 7 are set, and log bit 62 and status bit 6 stay clear.
- R4: While log bit 62 or 63 is set, a new CE strobe leaves log bits 0..61 unchanged.
- R5: A UE strobe arriving while only log bit 62 is set replaces the address and syndrome and sets bit 63. Bit 62 stays set.
- R6: Writing the log word clears bit 62 and/or bit 63 where the write data has a 1. All other written bits have no effect. After the flags are cleared, the stored address and syndrome remain readable until the next capture.
- R7: Writing the status register clears bit 6 and/or bit 7 where the write data has a 1. Writing 1s elsewhere has no effect.
- R8: The command register stores write-data bits 6 (CE enable) and 7 (UE enable). All its other bits read 0.
- R9: `irq_o` is high exactly while a status bit is set together with its command enable bit. It stays high until that bit is cleared or disabled.
- R10: A strobe sets no status bit unless the log flags and the status bits are all clear. A strobe that finds the log flags clear but a status bit set is still captured into the log.
- R11: A write-1 clear and an error strobe in the same cycle give priority to the strobe. The capture decision uses the state after the clear, so the new error is logged and, if everything is then clear, signalled.
- R12: Log bits 0..4 and 39..45 always read 0 in the default configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error strobe from the ECC checker |
| err_ce_i | input | 1 | Strobe carries a correctable error |
| err_ue_i | input | 1 | Strobe carries an uncorrectable error |
| err_addr_i | input | LOG_ADDR_HI-4 | Error address bits LOG_ADDR_HI..5 |
| err_synd_i | input | 16 | Error syndrome |
| reg_sel_i | input | 2 | Register select: 0 log, 1 status, 2 command |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The capture path is tried with a CE-only strobe, a UE-only strobe and a strobe carrying both flags. Together these tell apart the type precedence and the field placement, since the address and syndrome values use distinct bit patterns. Further strobes are applied with the log held, with only the status held, and with both clear. These separate the freeze of the log from the arming of the status register. A strobe in the same cycle as a write-1 clear shows whether the clear or the new error wins. Command values enabling CE, UE or both, against each pending type, show that the interrupt follows the per-type AND.

// File: rtl/ecc_err_log_pkg.sv
`timescale 1ns/1ps
package ecc_err_log_pkg;
  localparam int LOG_W   = 64;
  localparam int SYND_W  = 16;
  localparam int SYND_LO = 46;
  localparam int ADDR_LO = 5;
  localparam int UE_LOG  = 63;
  localparam int CE_LOG  = 62;
  localparam int UE_STS  = 7;
  localparam int CE_STS  = 6;

  typedef enum logic [1:0] {
    SEL_LOG = 2'd0,
    SEL_STS = 2'd1,
    SEL_CMD = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic ue;
    logic ce;
  } err_kind_t;
endpackage

// File: rtl/ecc_log_word.sv
`timescale 1ns/1ps
module ecc_log_word import ecc_err_log_pkg::*; #(
  parameter int LOG_ADDR_HI = 38
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ev_i,
  input  err_kind_t                  kind_i,
  input  logic [LOG_ADDR_HI:ADDR_LO] addr_i,
  input  logic [SYND_W-1:0]          synd_i,
  input  logic                       clr_i,
  input  err_kind_t                  clr_mask_i,
  output logic [LOG_W-1:0]           log_o,
  output logic                       busy_cl_o
);
  localparam int FLD_W = LOG_ADDR_HI - ADDR_LO + 1;
  localparam int GAP_W = SYND_LO - 1 - LOG_ADDR_HI;

  err_kind_t          flags_q, flags_cl;
  logic [FLD_W-1:0]   addr_q;
  logic [SYND_W-1:0]  synd_q;
  logic               take, upg;

  // clear is applied first, so a same-cycle event sees the cleared state
  always_comb begin
    flags_cl = err_kind_t'(flags_q & ~({2{clr_i}} & clr_mask_i));
    take     = ev_i && (flags_cl == '0);
    upg      = ev_i && kind_i.ue && flags_cl.ce && !flags_cl.ue;
  end

  assign busy_cl_o = (flags_cl != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      addr_q  <= '0;
      synd_q  <= '0;
    end else if (take || upg) begin
      addr_q  <= addr_i;
      synd_q  <= synd_i;
      flags_q <= take ? kind_i : '{ue: 1'b1, ce: 1'b1};
    end else begin
      flags_q <= flags_cl;
    end
  end

  generate
    if (GAP_W > 0) begin : g_narrow
      assign log_o = {flags_q.ue, flags_q.ce, synd_q, {GAP_W{1'b0}}, addr_q, {ADDR_LO{1'b0}}};
    end else begin : g_wide
      assign log_o = {flags_q.ue, flags_q.ce, synd_q, addr_q, {ADDR_LO{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/ecc_err_sts.sv
`timescale 1ns/1ps
module ecc_err_sts import ecc_err_log_pkg::*; (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ev_i,
  input  err_kind_t kind_i,
  input  logic      log_busy_cl_i,
  input  logic      sts_clr_i,
  input  logic      cmd_we_i,
  input  err_kind_t wmask_i,
  output err_kind_t sts_o,
  output err_kind_t cmd_o,
  output logic      irq_o
);
  err_kind_t sts_q, sts_cl, cmd_q;
  logic      armed;
  logic [1:0] hit;

  always_comb begin
    sts_cl = err_kind_t'(sts_q & ~({2{sts_clr_i}} & wmask_i));
    armed  = !log_busy_cl_i && (sts_cl == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      cmd_q <= '0;
    end else begin
      sts_q <= (ev_i && armed) ? kind_i : sts_cl;
      if (cmd_we_i) cmd_q <= wmask_i;
    end
  end

  generate
    for (genvar k = 0; k < 2; k++) begin : g_hit
      assign hit[k] = sts_q[k] & cmd_q[k];
    end
  endgenerate

  assign irq_o = |hit;
  assign sts_o = sts_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log import ecc_err_log_pkg::*; #(
  parameter int LOG_ADDR_HI = 38
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       err_valid_i,
  input  logic                       err_ce_i,
  input  logic                       err_ue_i,
  input  logic [LOG_ADDR_HI:ADDR_LO] err_addr_i,
  input  logic [SYND_W-1:0]          err_synd_i,
  input  logic [1:0]                 reg_sel_i,
  input  logic                       reg_we_i,
  input  logic [LOG_W-1:0]           reg_wdata_i,
  output logic [LOG_W-1:0]           reg_rdata_o,
  output logic                       irq_o
);
  logic             ev, wr_log, wr_sts, wr_cmd, log_busy_cl;
  err_kind_t        kind, log_mask, reg_mask, sts_bits, cmd_bits;
  logic [LOG_W-1:0] log_word;
  logic             unused_wdata;

  assign ev       = err_valid_i && (err_ce_i || err_ue_i);
  assign kind     = '{ue: err_ue_i, ce: err_ce_i && !err_ue_i};
  assign wr_log   = reg_we_i && (reg_sel_i == SEL_LOG);
  assign wr_sts   = reg_we_i && (reg_sel_i == SEL_STS);
  assign wr_cmd   = reg_we_i && (reg_sel_i == SEL_CMD);
  assign log_mask = '{ue: reg_wdata_i[UE_LOG], ce: reg_wdata_i[CE_LOG]};
  assign reg_mask = '{ue: reg_wdata_i[UE_STS], ce: reg_wdata_i[CE_STS]};
  assign unused_wdata = ^{reg_wdata_i[CE_LOG-1:UE_STS+1], reg_wdata_i[CE_STS-1:0]};

  ecc_log_word #(.LOG_ADDR_HI(LOG_ADDR_HI)) u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .kind_i     (kind),
    .addr_i     (err_addr_i),
    .synd_i     (err_synd_i),
    .clr_i      (wr_log),
    .clr_mask_i (log_mask),
    .log_o      (log_word),
    .busy_cl_o  (log_busy_cl)
  );

  ecc_err_sts u_sts (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ev_i          (ev),
    .kind_i        (kind),
    .log_busy_cl_i (log_busy_cl),
    .sts_clr_i     (wr_sts),
    .cmd_we_i      (wr_cmd),
    .wmask_i       (reg_mask),
    .sts_o         (sts_bits),
    .cmd_o         (cmd_bits),
    .irq_o         (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_LOG: reg_rdata_o = log_word;
      SEL_STS: reg_rdata_o[UE_STS:CE_STS] = sts_bits;
      SEL_CMD: reg_rdata_o[UE_STS:CE_STS] = cmd_bits;
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
`timescale 1ns/1ps
module ecc_err_log_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        err_valid_i,
  input logic        err_ce_i,
  input logic        err_ue_i,
  input logic [1:0]  reg_sel_i,
  input logic        reg_we_i,
  input logic        wdata_ue_i,
  input logic        irq_o,
  input logic [63:0] log_word,
  input logic [1:0]  sts_bits
);
  logic wr_log, wr_sts, wr_cmd;
  assign wr_log = reg_we_i && (reg_sel_i == 2'd0);
  assign wr_sts = reg_we_i && (reg_sel_i == 2'd1);
  assign wr_cmd = reg_we_i && (reg_sel_i == 2'd2);

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && err_ce_i && !err_ue_i && log_word[63:62] == 2'b00 && sts_bits == 2'b00)
    |=> (log_word[62] && sts_bits[0]));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_word[63:62] != 2'b00 && !wr_log && !(err_valid_i && err_ue_i && !log_word[63]))
    |=> $stable(log_word[61:0]));

  assert_upgrade_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_word[62] && !log_word[63] && err_valid_i && err_ue_i) |=> log_word[63]);

  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_log && wdata_ue_i && !err_valid_i) |=> !log_word[63]);

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(err_valid_i || wr_cmd));

  assert_no_resignal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_word[63:62] != 2'b00 && !wr_log && !wr_sts) |=> $stable(sts_bits));
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_valid_i (err_valid_i),
  .err_ce_i    (err_ce_i),
  .err_ue_i    (err_ue_i),
  .reg_sel_i   (reg_sel_i),
  .reg_we_i    (reg_we_i),
  .wdata_ue_i  (reg_wdata_i[63]),
  .irq_o       (irq_o),
  .log_word    (log_word),
  .sts_bits    (sts_bits)
);

// File: tb/tb_ecc_err_log.sv
`timescale 1ns/1ps
module tb_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        err_valid_i = 1'b0, err_ce_i = 1'b0, err_ue_i = 1'b0;
  logic [38:5] err_addr_i = '0;
  logic [15:0] err_synd_i = '0;
  logic [1:0]  reg_sel_i = 2'd0;
  logic        reg_we_i = 1'b0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] reg_rdata_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_log dut (
    .clk_i(clk), .rst_ni(rst_ni), .err_valid_i(err_valid_i), .err_ce_i(err_ce_i),
    .err_ue_i(err_ue_i), .err_addr_i(err_addr_i), .err_synd_i(err_synd_i),
    .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o));

  localparam logic [63:0] A1 = 64'h0000_2A5A_5A5A_5A7F;
  localparam logic [63:0] A2 = 64'h0000_1234_5678_9AE0;
  localparam logic [63:0] A3 = 64'h0000_0055_AA55_AA20;
  localparam logic [63:0] A4 = 64'h0000_3FFF_FFFF_FFFF;
  localparam logic [63:0] A5 = 64'h0000_0000_0000_0040;

  function automatic logic [63:0] mk(input logic ce, input logic ue,
                                     input logic [63:0] a, input logic [15:0] s);
    logic [63:0] r = '0;
    r[63] = ue;
    r[62] = ce & ~ue;
    r[61:46] = s;
    for (int i = 5; i <= 38; i++) r[i] = a[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [63:0] d);
    @(negedge clk);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic inject(input logic ce, input logic ue, input logic [63:0] a, input logic [15:0] s);
    @(negedge clk);
    err_valid_i = 1'b1; err_ce_i = ce; err_ue_i = ue;
    err_addr_i = a[38:5]; err_synd_i = s;
    @(negedge clk);
    err_valid_i = 1'b0; err_ce_i = 1'b0; err_ue_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    rd(2'd0, d); chk("R1 log after reset", d, 64'h0);
    rd(2'd1, d); chk("R1 status after reset", d, 64'h0);
    rd(2'd2, d); chk("R1 command after reset", d, 64'h0);
    rd(2'd3, d); chk("R1 unused select", d, 64'h0);
    chk("R1 irq after reset", {63'h0, irq_o}, 64'h0);
  endtask

  task automatic t_ce_capture;
    logic [63:0] d;
    inject(1'b1, 1'b0, A1, 16'hBEEF);
    rd(2'd0, d); chk("R2 CE capture", d, mk(1'b1, 1'b0, A1, 16'hBEEF));
    chk("R12 unused log bits zero", d & 64'h0000_3F80_0000_001F, 64'h0);
    rd(2'd1, d); chk("R2 status CE", d, 64'h40);
    chk("R9 irq off with no enable", {63'h0, irq_o}, 64'h0);
  endtask

  task automatic t_irq;
    logic [63:0] d;
    wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd2, d); chk("R8 command readback", d, 64'hC0);
    chk("R9 irq CE enabled", {63'h0, irq_o}, 64'h1);
    wr(2'd2, 64'h80);
    rd(2'd2, d); chk("R9 irq UE-only enable over CE", {63'h0, irq_o}, 64'h0);
    wr(2'd2, 64'hC0);
    rd(2'd2, d); chk("R9 irq re-enabled", {63'h0, irq_o}, 64'h1);
  endtask

  task automatic t_hold;
    logic [63:0] d;
    inject(1'b1, 1'b0, A2, 16'h1111);
    rd(2'd0, d); chk("R4 log frozen", d, mk(1'b1, 1'b0, A1, 16'hBEEF));
  endtask

  task automatic t_upgrade;
    logic [63:0] d;
    inject(1'b0, 1'b1, A2, 16'hC0DE);
    rd(2'd0, d); chk("R5 UE upgrade", d, mk(1'b0, 1'b1, A2, 16'hC0DE) | 64'h4000_0000_0000_0000);
    rd(2'd1, d); chk("R10 status not resignalled", d, 64'h40);
  endtask

  task automatic t_w1c;
    logic [63:0] d;
    wr(2'd0, 64'h3FFF_FFFF_FFFF_FFFF);
    rd(2'd0, d); chk("R6 non-flag bits ignored", d, mk(1'b0, 1'b1, A2, 16'hC0DE) | 64'h4000_0000_0000_0000);
    wr(2'd0, 64'h8000_0000_0000_0000);
    rd(2'd0, d); chk("R6 clear UE only", d, mk(1'b1, 1'b0, A2, 16'hC0DE));
    wr(2'd0, 64'h4000_0000_0000_0000);
    rd(2'd0, d); chk("R6 clear CE keeps fields", d, mk(1'b0, 1'b0, A2, 16'hC0DE));
  endtask

  task automatic t_rearm;
    logic [63:0] d;
    inject(1'b1, 1'b0, A3, 16'h0F0F);
    rd(2'd0, d); chk("R10 log captured while status held", d, mk(1'b1, 1'b0, A3, 16'h0F0F));
    rd(2'd1, d); chk("R10 status unchanged", d, 64'h40);
    wr(2'd1, 64'h40);
    rd(2'd1, d); chk("R7 status CE cleared", d, 64'h0);
    chk("R9 irq drops with status", {63'h0, irq_o}, 64'h0);
    inject(1'b1, 1'b0, A4, 16'h2222);
    rd(2'd1, d); chk("R10 no signal while log held", d, 64'h0);
    chk("R10 irq stays low", {63'h0, irq_o}, 64'h0);
    wr(2'd0, 64'hC000_0000_0000_0000);
    inject(1'b1, 1'b1, A4, 16'h5A5A);
    rd(2'd0, d); chk("R3 UE wins over CE", d, mk(1'b0, 1'b1, A4, 16'h5A5A));
    rd(2'd1, d); chk("R3 status UE", d, 64'h80);
    chk("R9 irq on UE", {63'h0, irq_o}, 64'h1);
  endtask

  task automatic t_sts_w1c;
    logic [63:0] d;
    wr(2'd1, 64'hFF7F);
    rd(2'd1, d); chk("R7 other bits ignored", d, 64'h80);
    wr(2'd1, 64'h80);
    rd(2'd1, d); chk("R7 status UE cleared", d, 64'h0);
  endtask

  task automatic t_same_cycle;
    logic [63:0] d;
    @(negedge clk);
    reg_sel_i = 2'd0; reg_wdata_i = 64'h8000_0000_0000_0000; reg_we_i = 1'b1;
    err_valid_i = 1'b1; err_ce_i = 1'b1; err_ue_i = 1'b0;
    err_addr_i = A5[38:5]; err_synd_i = 16'h7777;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0; err_valid_i = 1'b0; err_ce_i = 1'b0;
    rd(2'd0, d); chk("R11 event beats clear", d, mk(1'b1, 1'b0, A5, 16'h7777));
    rd(2'd1, d); chk("R11 signalled after clear", d, 64'h40);
    chk("R11 irq", {63'h0, irq_o}, 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_ce_capture();
    t_irq();
    t_hold();
    t_upgrade();
    t_w1c();
    t_rearm();
    t_sts_w1c();
    t_same_cycle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule